// File: doc/BRIEF.md
# Power domain gating sequencer

This block switches a single logic power domain off and back on under register control, running from a slow reference clock. A control word at offset 0x0 carries the software collapse request, a hardware-trigger enable, a software override with five direct drive bits, a flip-flop retention enable and three 4-bit wait exponents. A second, read-only word at offset 0x4 reports whether the domain has finished powering up or powering down. The sequencer drives the few-switch and rest-switch head-switch enables, the isolation clamp, the domain reset and the clock gate.

Every request starts with a fixed startup window of START_CYC cycles, during which the outputs and the power status keep their old values. After that the phases run one after another, each held for its programmed length: a field value n means 2^n reference cycles. A hardware request pin, sampled in the reference clock domain, can replace the collapse bit as the on/off command. A request that reverses direction partway through a sequence waits until the sequence has reached a stable on or off state.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset the control word reads 0x002820E1 (collapse=1, direct bits 7:3 = 5'b11100, enable-rest=2, enable-few=8, clock-disable=2, status 0), the configuration word reads 0x00008000, and the outputs are few=0, rest=0, clamp=1, reset=1, clock gate=1.
- R2: Power-up asserts the few switch first. The rest switch rises 2^EF cycles later, the clamp drops 2^ER cycles after that, the reset drops 2^CD cycles after that, and the clock gate drops CLK_HOLD (4) cycles after the reset. EF is control bits 19:16, ER bits 23:20 and CD bits 15:12.
- R3: Power-down raises the clock gate first. The reset rises 2^CD cycles later, the clamp 2^CD cycles after that, the rest switch drops 2^CD cycles after that, and the few switch drops 2^ER cycles after that. The off state is reached 2^EF cycles after the few switch drops.
- R4: The first output change of a sequence, and the change of the status bit, come START_CYC+1 (9) cycles after the clock edge on which the request took effect. Before then the status keeps its old value.
- R5: Control bit 31 reads 1 from the start of the few-switch phase of power-up until the clock gate rises on power-down, and 0 otherwise. Configuration bit 16 is 1 only in the fully on state, and configuration bit 15 is 1 only in the fully off state.
- R6: A reversing request during power-up or power-down takes effect only after the stable state is reached. The reversed sequence then starts one cycle later and runs its full startup window, so the first output change comes 9 cycles after the stable state is entered.
- R7: With hardware-trigger enable (control bit 1) set, hw_req=1 commands power-on and hw_req=0 commands power-off, with the same 9-cycle startup as R4. Writes to the collapse bit then have no effect.
- R8: A change to the hardware-trigger enable takes effect only in a stable state. Clearing it mid-sequence lets the hardware command finish, and the collapse bit takes control one cycle after the stable state is entered.
- R9: With software override (control bit 2) set, the sequencer holds its state and the outputs follow control bits 7:3 directly (bit 7 clock gate, 6 reset, 5 clamp, 4 rest, 3 few). Clearing the override resumes sequencing from the held state.
- R10: Writes to offset 0x4 change nothing. Control bit 11 drives ff_ret_en and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset (0x0 control, 0x4 configuration) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hw_req | input | 1 | Hardware power request, 1 = on |
| hs_few_en | output | 1 | Few-switch head-switch enable |
| hs_rest_en | output | 1 | Rest-switch head-switch enable |
| clamp_en | output | 1 | Isolation clamp, 1 = clamped |
| dom_rst | output | 1 | Domain reset, 1 = held in reset |
| clk_gate | output | 1 | Clock gate, 1 = clocks stopped |
| ff_ret_en | output | 1 | Flip-flop retention enable |

## Verification
The bench sweeps every combination of the three wait exponents over 0 to 3, plus the reset defaults, and measures the gap between successive output edges in both directions. An off-by-one counter, a swapped wait field or a mis-ordered phase shows up there as a wrong gap. The startup window is timed from the write edge, so a sequencer that moved the status early, or skipped the window, misses the 9-cycle mark. Reversals in the middle of a sequence, the hardware-trigger hand-back (whose 10-cycle on time shows whether the enable was latched only in a stable state), the override freeze and writes to the read-only word are each timed or checked at the pins. A design that reversed at once, handed back control early or kept stepping under override would produce a different edge time or pattern.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int unsigned WAIT_W    = 4;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned DIR_W     = 5;
  // control word bit positions
  localparam int unsigned B_COLLAPSE = 0;
  localparam int unsigned B_HWTRIG   = 1;
  localparam int unsigned B_OVR      = 2;
  localparam int unsigned B_DIR_LSB  = 3;
  localparam int unsigned B_RET      = 11;
  localparam int unsigned B_CD_LSB   = 12;
  localparam int unsigned B_EF_LSB   = 16;
  localparam int unsigned B_ER_LSB   = 20;
  localparam int unsigned B_STATUS   = 31;
  // configuration word bit positions
  localparam int unsigned B_DN_DONE  = 15;
  localparam int unsigned B_UP_DONE  = 16;
  localparam int unsigned CFG_OFS    = 4;

  typedef enum logic [3:0] {
    ST_OFF, ST_UP_WAKE, ST_UP_FEW, ST_UP_REST, ST_UP_CLAMP, ST_UP_RST, ST_ON,
    ST_DN_WAKE, ST_DN_CLK, ST_DN_RST, ST_DN_CLAMP, ST_DN_REST, ST_DN_FEW
  } pgs_state_e;

  // field order matches direct drive bits 7:3
  typedef struct packed {
    logic clk_gate;
    logic rst;
    logic clamp;
    logic rest;
    logic few;
  } pgs_drv_t;

  function automatic pgs_drv_t state_drive(input pgs_state_e s);
    pgs_drv_t d;
    case (s)
      ST_UP_FEW, ST_DN_REST:   d = 5'b11101;
      ST_UP_REST, ST_DN_CLAMP: d = 5'b11111;
      ST_UP_CLAMP, ST_DN_RST:  d = 5'b11011;
      ST_UP_RST, ST_DN_CLK:    d = 5'b10011;
      ST_ON, ST_DN_WAKE:       d = 5'b00011;
      default:                 d = 5'b11100;
    endcase
    return d;
  endfunction

  function automatic logic is_stable(input pgs_state_e s);
    return (s == ST_OFF) || (s == ST_ON);
  endfunction

  function automatic logic is_powered(input pgs_state_e s);
    return s inside {ST_UP_FEW, ST_UP_REST, ST_UP_CLAMP, ST_UP_RST, ST_ON, ST_DN_WAKE};
  endfunction

  function automatic logic is_rising(input pgs_state_e s);
    return s inside {ST_UP_WAKE, ST_UP_FEW, ST_UP_REST, ST_UP_CLAMP, ST_UP_RST};
  endfunction

  function automatic logic is_falling(input pgs_state_e s);
    return s inside {ST_DN_WAKE, ST_DN_CLK, ST_DN_RST, ST_DN_CLAMP, ST_DN_REST, ST_DN_FEW};
  endfunction

  function automatic pgs_state_e succ(input pgs_state_e s);
    case (s)
      ST_UP_WAKE:  return ST_UP_FEW;
      ST_UP_FEW:   return ST_UP_REST;
      ST_UP_REST:  return ST_UP_CLAMP;
      ST_UP_CLAMP: return ST_UP_RST;
      ST_UP_RST:   return ST_ON;
      ST_DN_WAKE:  return ST_DN_CLK;
      ST_DN_CLK:   return ST_DN_RST;
      ST_DN_RST:   return ST_DN_CLAMP;
      ST_DN_CLAMP: return ST_DN_REST;
      ST_DN_REST:  return ST_DN_FEW;
      ST_DN_FEW:   return ST_OFF;
      default:     return s;
    endcase
  endfunction

  function automatic logic [31:0] pow2(input logic [WAIT_W-1:0] n);
    return 32'd1 << n;
  endfunction

  // number of cycles a phase is held
  function automatic logic [31:0] phase_len(input pgs_state_e s,
                                            input logic [WAIT_W-1:0] er,
                                            input logic [WAIT_W-1:0] ef,
                                            input logic [WAIT_W-1:0] cd,
                                            input logic [31:0] start_len,
                                            input logic [31:0] clk_len);
    case (s)
      ST_UP_WAKE, ST_DN_WAKE:                       return start_len;
      ST_UP_FEW, ST_DN_FEW:                         return pow2(ef);
      ST_UP_REST, ST_DN_REST:                       return pow2(er);
      ST_UP_CLAMP, ST_DN_CLK, ST_DN_RST, ST_DN_CLAMP: return pow2(cd);
      ST_UP_RST:                                    return clk_len;
      default:                                      return 32'd1;
    endcase
  endfunction
endpackage

// File: rtl/pgs_regs.sv
module pgs_regs import pgs_pkg::*; #(
  parameter int unsigned ADDR_W = 3,
  parameter logic [WAIT_W-1:0] RST_ER = 4'd2,
  parameter logic [WAIT_W-1:0] RST_EF = 4'd8,
  parameter logic [WAIT_W-1:0] RST_CD = 4'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              status,
  input  logic              up_done,
  input  logic              dn_done,
  output logic              collapse,
  output logic              hw_en,
  output logic              ovr,
  output pgs_drv_t          direct,
  output logic              ret_en,
  output logic [WAIT_W-1:0] er,
  output logic [WAIT_W-1:0] ef,
  output logic [WAIT_W-1:0] cd
);
  localparam logic [ADDR_W-1:0] A_CTRL = '0;
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_OFS);

  logic ctrl_wr;
  logic [DATA_W-1:0] ctrl_word, cfg_word;
  logic unused_wbits;

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign unused_wbits = ^{reg_wdata[30:24], reg_wdata[10:8], reg_wdata[31]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      collapse <= 1'b1;
      hw_en    <= 1'b0;
      ovr      <= 1'b0;
      direct   <= 5'b11100;
      ret_en   <= 1'b0;
      er       <= RST_ER;
      ef       <= RST_EF;
      cd       <= RST_CD;
    end else if (ctrl_wr) begin
      collapse <= reg_wdata[B_COLLAPSE];
      hw_en    <= reg_wdata[B_HWTRIG];
      ovr      <= reg_wdata[B_OVR];
      direct   <= reg_wdata[B_DIR_LSB +: DIR_W];
      ret_en   <= reg_wdata[B_RET];
      er       <= reg_wdata[B_ER_LSB +: WAIT_W];
      ef       <= reg_wdata[B_EF_LSB +: WAIT_W];
      cd       <= reg_wdata[B_CD_LSB +: WAIT_W];
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_COLLAPSE] = collapse;
    ctrl_word[B_HWTRIG]   = hw_en;
    ctrl_word[B_OVR]      = ovr;
    ctrl_word[B_DIR_LSB +: DIR_W] = direct;
    ctrl_word[B_RET]      = ret_en;
    ctrl_word[B_CD_LSB +: WAIT_W] = cd;
    ctrl_word[B_EF_LSB +: WAIT_W] = ef;
    ctrl_word[B_ER_LSB +: WAIT_W] = er;
    ctrl_word[B_STATUS]   = status;
    cfg_word = '0;
    cfg_word[B_UP_DONE] = up_done;
    cfg_word[B_DN_DONE] = dn_done;
    if (reg_addr == A_CTRL)     reg_rdata = ctrl_word;
    else if (reg_addr == A_CFG) reg_rdata = cfg_word;
    else                        reg_rdata = '0;
  end

  // R10
  cfg_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CFG) |=> $stable({collapse, hw_en, ovr, direct, ret_en, er, ef, cd}));
endmodule

// File: rtl/pgs_arb.sv
module pgs_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_en,
  input  logic collapse,
  input  logic hw_req,
  input  logic stable,
  output logic cmd_on
);
  logic hw_mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hw_mode_q <= 1'b0;
    else if (stable) hw_mode_q <= hw_en;
  end

  assign cmd_on = hw_mode_q ? hw_req : ~collapse;

  // R8
  hand_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode_q != $past(hw_mode_q)) |-> $past(stable));
endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm import pgs_pkg::*; #(
  parameter int unsigned START_CYC = 8,
  parameter int unsigned CLK_HOLD  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_on,
  input  logic              freeze,
  input  logic [WAIT_W-1:0] er,
  input  logic [WAIT_W-1:0] ef,
  input  logic [WAIT_W-1:0] cd,
  output pgs_state_e        state
);
  localparam int unsigned CNT_W = (1 << WAIT_W) + 1;

  pgs_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0] hold_len;
  logic phase_done;

  assign hold_len   = phase_len(state_q, er, ef, cd, 32'(START_CYC), 32'(CLK_HOLD));
  assign phase_done = ({15'd0, cnt_q} >= (hold_len - 32'd1));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF:  if (cmd_on)  state_d = ST_UP_WAKE;
      ST_ON:   if (!cmd_on) state_d = ST_DN_WAKE;
      default: if (phase_done) state_d = succ(state_q);
    endcase
    if (freeze) state_d = state_q;
  end

  always_comb begin
    if (freeze)                                        cnt_d = cnt_q;
    else if (state_d != state_q || is_stable(state_q)) cnt_d = '0;
    else                                               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;

  // R2
  phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q) && !is_stable($past(state_q))) |-> $past(phase_done));
  // R6
  no_reverse_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rising(state_q) |=> (is_rising(state_q) || state_q == ST_ON));
  // R6
  no_reverse_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_falling(state_q) |=> (is_falling(state_q) || state_q == ST_OFF));
  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(state_q));
endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq import pgs_pkg::*; #(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned START_CYC = 8,
  parameter int unsigned CLK_HOLD  = 4,
  parameter logic [WAIT_W-1:0] RST_ER = 4'd2,
  parameter logic [WAIT_W-1:0] RST_EF = 4'd8,
  parameter logic [WAIT_W-1:0] RST_CD = 4'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              hw_req,
  output logic              hs_few_en,
  output logic              hs_rest_en,
  output logic              clamp_en,
  output logic              dom_rst,
  output logic              clk_gate,
  output logic              ff_ret_en
);
  logic collapse, hw_en, ovr, ret_en;
  logic [WAIT_W-1:0] er, ef, cd;
  pgs_drv_t direct, drv;
  pgs_state_e state;
  logic cmd_on, status, up_done, dn_done, stable;

  assign status  = is_powered(state);
  assign up_done = (state == ST_ON);
  assign dn_done = (state == ST_OFF);
  assign stable  = is_stable(state);

  pgs_regs #(.ADDR_W(ADDR_W), .RST_ER(RST_ER), .RST_EF(RST_EF), .RST_CD(RST_CD)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status(status),
    .up_done(up_done), .dn_done(dn_done), .collapse(collapse), .hw_en(hw_en),
    .ovr(ovr), .direct(direct), .ret_en(ret_en), .er(er), .ef(ef), .cd(cd)
  );

  pgs_arb u_arb (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .collapse(collapse),
    .hw_req(hw_req), .stable(stable), .cmd_on(cmd_on)
  );

  pgs_fsm #(.START_CYC(START_CYC), .CLK_HOLD(CLK_HOLD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .freeze(ovr),
    .er(er), .ef(ef), .cd(cd), .state(state)
  );

  assign drv        = ovr ? direct : state_drive(state);
  assign hs_few_en  = drv.few;
  assign hs_rest_en = drv.rest;
  assign clamp_en   = drv.clamp;
  assign dom_rst    = drv.rst;
  assign clk_gate   = drv.clk_gate;
  assign ff_ret_en  = ret_en;

  // R4
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(state) == ST_UP_WAKE);
  // R4
  status_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status) |-> $past(state) == ST_DN_WAKE);
  // R2
  clock_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr && !clk_gate) |-> (!clamp_en && !dom_rst && hs_rest_en && hs_few_en));
endmodule

// File: tb/pwr_gate_seq_tb.sv
module pwr_gate_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic hw_req = 1'b0;
  logic hs_few_en, hs_rest_en, clamp_en, dom_rst, clk_gate, ff_ret_en;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int t0;
  logic [3:0] b_er = 4'd2, b_ef = 4'd8, b_cd = 4'd2;
  logic b_col = 1'b1, b_hw = 1'b0, b_ovr = 1'b0, b_ret = 1'b0;
  logic [4:0] b_dir = 5'b11100;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_gate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
    .hs_few_en(hs_few_en), .hs_rest_en(hs_rest_en), .clamp_en(clamp_en),
    .dom_rst(dom_rst), .clk_gate(clk_gate), .ff_ret_en(ff_ret_en)
  );

  function automatic logic [31:0] ctrl_word();
    logic [31:0] w;
    w = '0;
    w[0] = b_col; w[1] = b_hw; w[2] = b_ovr; w[7:3] = b_dir; w[11] = b_ret;
    w[15:12] = b_cd; w[19:16] = b_ef; w[23:20] = b_er;
    return w;
  endfunction

  function automatic logic sig(input int sel);
    case (sel)
      0: return hs_few_en;
      1: return hs_rest_en;
      2: return clamp_en;
      3: return dom_rst;
      4: return clk_gate;
      5: return reg_rdata[31];
      6: return reg_rdata[16];
      default: return reg_rdata[15];
    endcase
  endfunction

  function automatic logic [4:0] outs();
    return {clk_gate, dom_rst, clamp_en, hs_rest_en, hs_few_en};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd0;
    t0 = cyc;
  endtask

  task automatic put_ctrl();
    put(3'd0, ctrl_word());
  endtask

  task automatic wait_sig(input int sel, input logic val, output int t);
    t = -1;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (sig(sel) == val) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic settle_off();
    int t;
    reg_addr = 3'd4;
    wait_sig(7, 1'b1, t);
    reg_addr = 3'd0;
    chk(t >= 0, "R3", "reached off", t, 0);
  endtask

  task automatic run_up();
    int ts, t1, t2, t3, t4;
    b_col = 1'b0;
    put_ctrl();
    wait_sig(5, 1'b1, ts);
    chk(ts - t0 == 9, "R4", "request to status rise", ts - t0, 9);
    chk(hs_few_en == 1'b1, "R2", "few switch with status", hs_few_en, 1);
    wait_sig(1, 1'b1, t1);
    chk(t1 - ts == (1 << b_ef), "R2", "few to rest", t1 - ts, 1 << b_ef);
    wait_sig(2, 1'b0, t2);
    chk(t2 - t1 == (1 << b_er), "R2", "rest to unclamp", t2 - t1, 1 << b_er);
    wait_sig(3, 1'b0, t3);
    chk(t3 - t2 == (1 << b_cd), "R2", "unclamp to unreset", t3 - t2, 1 << b_cd);
    wait_sig(4, 1'b0, t4);
    chk(t4 - t3 == 4, "R2", "unreset to clocks", t4 - t3, 4);
    reg_addr = 3'd4;
    #1;
    chk(reg_rdata == 32'h0001_0000, "R5", "cfg word when on", reg_rdata, 32'h0001_0000);
    reg_addr = 3'd0;
  endtask

  task automatic run_dn();
    int tg, t1, t2, t3, t4, t5;
    b_col = 1'b1;
    put_ctrl();
    wait_sig(4, 1'b1, tg);
    chk(tg - t0 == 9, "R4", "request to clock gate", tg - t0, 9);
    chk(reg_rdata[31] == 1'b0, "R5", "status with clock gate", reg_rdata[31], 0);
    wait_sig(3, 1'b1, t1);
    chk(t1 - tg == (1 << b_cd), "R3", "gate to reset", t1 - tg, 1 << b_cd);
    wait_sig(2, 1'b1, t2);
    chk(t2 - t1 == (1 << b_cd), "R3", "reset to clamp", t2 - t1, 1 << b_cd);
    wait_sig(1, 1'b0, t3);
    chk(t3 - t2 == (1 << b_cd), "R3", "clamp to rest off", t3 - t2, 1 << b_cd);
    wait_sig(0, 1'b0, t4);
    chk(t4 - t3 == (1 << b_er), "R3", "rest off to few off", t4 - t3, 1 << b_er);
    reg_addr = 3'd4;
    wait_sig(7, 1'b1, t5);
    chk(t5 - t4 == (1 << b_ef), "R3", "few off to off state", t5 - t4, 1 << b_ef);
    chk(reg_rdata == 32'h0000_8000, "R5", "cfg word when off", reg_rdata, 32'h0000_8000);
    reg_addr = 3'd0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ta, tb, tc, td;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(reg_rdata == 32'h0028_20E1, "R1", "control word", reg_rdata, 32'h0028_20E1);
    chk(outs() == 5'b11100, "R1", "outputs", outs(), 5'b11100);
    reg_addr = 3'd4;
    #1;
    chk(reg_rdata == 32'h0000_8000, "R1", "cfg word", reg_rdata, 32'h0000_8000);
    reg_addr = 3'd0;

    // default waits
    run_up();
    run_dn();

    // sweep of wait exponents
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          b_er = 4'(a); b_ef = 4'(b); b_cd = 4'(c);
          run_up();
          run_dn();
        end

    b_er = 4'd1; b_ef = 4'd2; b_cd = 4'd1;
    // R6 reversal during power-up
    b_col = 1'b0; put_ctrl();
    wait_sig(0, 1'b1, ta);
    b_col = 1'b1; put_ctrl();
    wait_sig(1, 1'b1, tb);
    chk(tb >= 0 && hs_few_en, "R6", "up continues after reverse", tb, 1);
    wait_sig(4, 1'b0, ta);
    wait_sig(4, 1'b1, tb);
    chk(tb - ta == 9, "R6", "on time before deferred down", tb - ta, 9);
    // R6 reversal during power-down
    b_col = 1'b0; put_ctrl();
    settle_off();
    tc = cyc;
    wait_sig(0, 1'b1, td);
    chk(td - tc == 9, "R6", "off time before deferred up", td - tc, 9);
    wait_sig(4, 1'b0, ta);
    b_col = 1'b1; put_ctrl();
    settle_off();

    // R7 hardware trigger
    b_hw = 1'b1; b_col = 1'b1; put_ctrl();
    repeat (2) @(negedge clk);
    hw_req = 1'b1; tc = cyc;
    wait_sig(0, 1'b1, td);
    chk(td - tc == 9, "R7", "hw request to few", td - tc, 9);
    wait_sig(4, 1'b0, ta);
    b_col = 1'b0; put_ctrl();
    @(negedge clk);
    hw_req = 1'b0; tc = cyc;
    wait_sig(4, 1'b1, td);
    chk(td - tc == 9, "R7", "hw release to clock gate", td - tc, 9);
    settle_off();
    b_col = 1'b0; put_ctrl();
    repeat (40) @(negedge clk);
    chk(hs_few_en == 1'b0 && reg_rdata[31] == 1'b0, "R7", "collapse ignored in hw mode",
        {hs_few_en, reg_rdata[31]}, 0);

    // R8 hand-back only at stable state
    hw_req = 1'b1;
    repeat (3) @(negedge clk);
    b_hw = 1'b0; b_col = 1'b1; put_ctrl();
    wait_sig(4, 1'b0, ta);
    chk(ta >= 0, "R8", "hw command finished", ta, 0);
    wait_sig(4, 1'b1, tb);
    chk(tb - ta == 10, "R8", "on time at hand-back", tb - ta, 10);
    settle_off();
    repeat (40) @(negedge clk);
    chk(hs_few_en == 1'b0, "R8", "hw_req ignored after hand-back", hs_few_en, 0);
    hw_req = 1'b0;

    // R9 software override
    b_ovr = 1'b1; b_col = 1'b0; b_dir = 5'b01010; put_ctrl();
    #1;
    chk(outs() == 5'b01010, "R9", "direct drive pattern A", outs(), 5'b01010);
    repeat (30) @(negedge clk);
    chk(outs() == 5'b01010 && reg_rdata[31] == 1'b0, "R9", "frozen under override",
        {outs(), reg_rdata[31]}, {5'b01010, 1'b0});
    b_dir = 5'b10101; put_ctrl();
    #1;
    chk(outs() == 5'b10101, "R9", "direct drive pattern B", outs(), 5'b10101);
    b_ovr = 1'b0; b_dir = 5'b11100; put_ctrl();
    #1;
    chk(outs() == 5'b11100, "R9", "state drive restored", outs(), 5'b11100);
    wait_sig(5, 1'b1, ta);
    chk(ta - t0 == 9, "R9", "sequencing resumes", ta - t0, 9);
    wait_sig(4, 1'b0, ta);

    // R10 retention and read-only word
    b_ret = 1'b1; put_ctrl();
    #1;
    chk(ff_ret_en == 1'b1 && reg_rdata[11] == 1'b1, "R10", "retention enable",
        {ff_ret_en, reg_rdata[11]}, 3);
    put(3'd4, 32'hFFFF_FFFF);
    #1;
    chk(reg_rdata == (ctrl_word() | 32'h8000_0000), "R10", "ctrl after cfg write",
        reg_rdata, ctrl_word() | 32'h8000_0000);
    repeat (20) @(negedge clk);
    chk(outs() == 5'b00011, "R10", "outputs after cfg write", outs(), 5'b00011);
    reg_addr = 3'd4;
    #1;
    chk(reg_rdata == 32'h0001_0000, "R10", "cfg after cfg write", reg_rdata, 32'h0001_0000);
    reg_addr = 3'd0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule